// File: doc/BRIEF.md
# Non-power-of-two flash address translator

This block turns a linear byte address into the page/offset address a serial flash expects when its pages are 264 or 528 bytes long. The page number is the linear address divided by the page size. It is placed above a fixed bit position: bit 9 for the 264-byte page and bit 10 for the 528-byte page. The remainder of that division fills the bits below it. Because the page size is not a power of two, the quotient and remainder come from a small sequential divider. The divider produces one quotient bit per clock.

A conversion begins when `start` is sampled high while the block is idle. At that edge the block also captures the address, the page-size select and the mode flag. In power-of-two mode the address passes through unchanged and the result is ready one cycle later. In the default mode the division runs for one cycle per address bit. A one-cycle `done` pulse marks a new result. `dev_addr` keeps that result until the next conversion finishes.

Top module: `flash_addr_xlate`

## Requirements
- R1: While `rst_n` is low, `busy` and `done` are 0 and `dev_addr` is 0.
- R2: In default mode (`pow2_mode`=0), the low bits of `dev_addr` hold the linear address modulo the page size. `page_sel`=0 selects 264 bytes and `page_sel`=1 selects 528 bytes.
- R3: With `page_sel`=0, `dev_addr` bits [23:9] hold the linear address divided by 264, truncated to fit 24 bits.
- R4: With `page_sel`=1, `dev_addr` bits [23:10] hold the linear address divided by 528, truncated to fit 24 bits.
- R5: With `pow2_mode`=1 at the accepted start, `done` is high in the cycle after the start edge and `dev_addr` equals the captured `lin_addr`.
- R6: A default-mode conversion raises `busy` for 24 cycles. `done` goes high after the 25th rising edge, counting the edge that accepted `start`. `busy` and `done` are never high together.
- R7: `done` is a single-cycle pulse per conversion.
- R8: `dev_addr` changes only in a cycle in which `done` is high, and otherwise holds its last value.
- R9: A `start` sampled while `busy` is high is ignored. It neither alters the running conversion's result or timing nor begins a new conversion.
- R10: At a page edge, address page_size−1 maps to page 0 with offset page_size−1. Address page_size maps to page 1 with offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion; honoured only when idle |
| lin_addr | input | 24 | Linear byte address |
| page_sel | input | 1 | Page size: 0 = 264 bytes, 1 = 528 bytes |
| pow2_mode | input | 1 | 1 = pass the address through untranslated |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: new result on dev_addr |
| dev_addr | output | 24 | Translated device address |

## Verification
A misstep in the divider's remainder register or quotient shift shows at the ports only when `done` pulses. It appears as a wrong offset or page field in `dev_addr`, 25 cycles after the start. A fault in the control state or the bit counter shows sooner. `busy` or `done` diverges from the reference model in the very cycle the sequence goes wrong. A start that is wrongly accepted also shows within a cycle: `busy` or `done` takes the wrong value, or `dev_addr` changes outside a `done` cycle. Page-edge addresses make any off-by-one in the compare-and-subtract step visible as an offset equal to the page size or a page number one too small.

// File: rtl/flash_xlate_pkg.sv
package flash_xlate_pkg;

    localparam int ADDR_W     = 24;
    localparam int PAGE_SMALL = 264;
    localparam int PAGE_LARGE = 528;
    localparam int SHIFT_KNEE = 512;

    // Bit position of the page field for a given page size.
    function automatic int page_shift(input int page_bytes);
        return (page_bytes > SHIFT_KNEE) ? 10 : 9;
    endfunction

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_DIVIDE = 1'b1
    } xlate_state_e;

endpackage

// File: rtl/flash_xlate_div.sv
module flash_xlate_div #(
    parameter int W  = 24,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic [W-1:0]  quot_nxt,
    output logic [DW-1:0] rem_nxt,
    output logic          last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W-1:0]  work;
        logic [DW-1:0] rem;
        logic [DW-1:0] dvs;
    } div_reg_t;

    div_reg_t q, d;
    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        fits;

    always_comb begin
        d     = q;
        trial = {q.rem, q.work[W-1]};
        diff  = trial - {1'b0, q.dvs};
        fits  = (trial >= {1'b0, q.dvs});
        last  = q.run && (q.cnt == CW'(W - 1));
        if (load) begin
            d.run  = 1'b1;
            d.cnt  = '0;
            d.work = dividend;
            d.rem  = '0;
            d.dvs  = divisor;
        end else if (q.run) begin
            d.rem  = fits ? diff[DW-1:0] : trial[DW-1:0];
            d.work = {q.work[W-2:0], fits};
            d.cnt  = q.cnt + 1'b1;
            if (last) begin
                d.run = 1'b0;
            end
        end
        quot_nxt = d.work;
        rem_nxt  = d.rem;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/flash_xlate_pack.sv
module flash_xlate_pack #(
    parameter int W        = 24,
    parameter int DW       = 10,
    parameter int SH_SMALL = 9,
    parameter int SH_LARGE = 10
) (
    input  logic          wide_page,
    input  logic [W-1:0]  quotient,
    input  logic [DW-1:0] remainder,
    output logic [W-1:0]  packed_addr
);
    logic [W-1:0] shifted;

    always_comb begin
        shifted     = wide_page ? (quotient << SH_LARGE) : (quotient << SH_SMALL);
        packed_addr = shifted | W'(remainder);
    end

endmodule

// File: rtl/flash_addr_xlate.sv
module flash_addr_xlate
    import flash_xlate_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int PG_SMALL  = PAGE_SMALL,
    parameter int PG_LARGE  = PAGE_LARGE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] lin_addr,
    input  logic          page_sel,
    input  logic          pow2_mode,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] dev_addr
);
    localparam int DW       = $clog2(PG_LARGE + 1);
    localparam int SH_SMALL = page_shift(PG_SMALL);
    localparam int SH_LARGE = page_shift(PG_LARGE);

    typedef struct packed {
        xlate_state_e  st;
        logic          wide;
        logic          done;
        logic [AW-1:0] result;
    } ctl_reg_t;

    ctl_reg_t q, d;

    logic          div_load;
    logic [DW-1:0] div_divisor;
    logic [AW-1:0] quot_nxt;
    logic [DW-1:0] rem_nxt;
    logic          div_last;
    logic [AW-1:0] packed_addr;

    flash_xlate_div #(
        .W  (AW),
        .DW (DW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (lin_addr),
        .divisor  (div_divisor),
        .quot_nxt (quot_nxt),
        .rem_nxt  (rem_nxt),
        .last     (div_last)
    );

    flash_xlate_pack #(
        .W        (AW),
        .DW       (DW),
        .SH_SMALL (SH_SMALL),
        .SH_LARGE (SH_LARGE)
    ) u_pack (
        .wide_page   (q.wide),
        .quotient    (quot_nxt),
        .remainder   (rem_nxt),
        .packed_addr (packed_addr)
    );

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        div_load    = 1'b0;
        div_divisor = page_sel ? DW'(PG_LARGE) : DW'(PG_SMALL);
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (pow2_mode) begin
                        d.result = lin_addr;
                        d.done   = 1'b1;
                    end else begin
                        div_load = 1'b1;
                        d.wide   = page_sel;
                        d.st     = ST_DIVIDE;
                    end
                end
            end
            ST_DIVIDE: begin
                if (div_last) begin
                    d.result = packed_addr;
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st == ST_DIVIDE);
    assign done     = q.done;
    assign dev_addr = q.result;

endmodule

// File: rtl/flash_addr_xlate_chk.sv
module flash_addr_xlate_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] lin_addr,
    input logic          pow2_mode,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] dev_addr
);
    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R1: outputs cleared while reset is held
    always @(negedge clk) begin
        if (seen_edge === 1'b1 && !rst_n) begin
            p_reset_clear_r1: assert (!busy && !done && dev_addr == '0)
                else $error("reset state not clear");
        end
    end

    p_pass_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && pow2_mode) |=> (done && dev_addr == $past(lin_addr)));

    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_busy_spans_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(dev_addr));

endmodule

bind flash_addr_xlate flash_addr_xlate_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lin_addr  (lin_addr),
    .pow2_mode (pow2_mode),
    .busy      (busy),
    .done      (done),
    .dev_addr  (dev_addr)
);

// File: tb/flash_addr_xlate_bench.sv
module flash_addr_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] lin_addr = '0;
    logic        page_sel = 1'b0;
    logic        pow2_mode = 1'b0;
    logic        busy;
    logic        done;
    logic [23:0] dev_addr;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_addr_xlate u_flash_addr_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lin_addr  (lin_addr),
        .page_sel  (page_sel),
        .pow2_mode (pow2_mode),
        .busy      (busy),
        .done      (done),
        .dev_addr  (dev_addr)
    );

    function automatic int unsigned ref_conv(input int unsigned a, input bit big);
        int unsigned p;
        int unsigned sh;
        p  = big ? 528 : 264;
        sh = big ? 10 : 9;
        return (((a / p) << sh) | (a % p)) & 32'h00FF_FFFF;
    endfunction

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: counts remaining divide cycles
    int          m_cnt = 0;
    bit          m_done = 1'b0;
    int unsigned m_addr = 0;
    int unsigned m_pend = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  <= 0;
            m_done <= 1'b0;
            m_addr <= 0;
        end else begin
            m_done <= 1'b0;
            if (m_cnt == 0) begin
                if (start) begin
                    if (pow2_mode) begin
                        m_addr <= lin_addr;
                        m_done <= 1'b1;
                    end else begin
                        m_cnt  <= 24;
                        m_pend <= ref_conv(lin_addr, page_sel);
                    end
                end
            end else begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) begin
                    m_done <= 1'b1;
                    m_addr <= m_pend;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R6 busy", busy, (m_cnt != 0));
            check("R7 done", done, m_done);
            check("R8 dev_addr", dev_addr, m_addr);
        end
    end

    task automatic run_conv(input int unsigned a, input bit big, input bit p2,
                            output int lat);
        @(posedge clk); #2;
        start = 1'b1; lin_addr = a[23:0]; page_sel = big; pow2_mode = p2;
        @(posedge clk); #2;
        start = 1'b0;
        lat = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            lat++;
            if (done) break;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 dev_addr", dev_addr, 0);
        @(posedge clk); #2 rst_n = 1'b1;

        run_conv(0, 0, 0, lat);
        check("R6 latency", lat, 25);
        check("R2 zero", dev_addr, 0);
        run_conv(263, 0, 0, lat);
        check("R10 last byte 264", dev_addr, 263);
        run_conv(264, 0, 0, lat);
        check("R10 next page 264", dev_addr, 512);
        run_conv(1000, 0, 0, lat);
        check("R2 offset 264", dev_addr & 32'h1FF, 208);
        check("R3 page 264", dev_addr >> 9, 3);
        run_conv(24'h3FFFFF, 0, 0, lat);
        check("R3 top 264", dev_addr, ref_conv(24'h3FFFFF, 0));
        run_conv(527, 1, 0, lat);
        check("R10 last byte 528", dev_addr, 527);
        run_conv(528, 1, 0, lat);
        check("R10 next page 528", dev_addr, 1024);
        run_conv(12345, 1, 0, lat);
        check("R4 page 528", dev_addr >> 10, 23);
        check("R2 offset 528", dev_addr & 32'h3FF, 201);
        run_conv(24'h3FFFFF, 1, 0, lat);
        check("R4 top 528", dev_addr, ref_conv(24'h3FFFFF, 1));
        run_conv(24'h0ABCDE, 1, 1, lat);
        check("R5 latency", lat, 1);
        check("R5 pass", dev_addr, 24'h0ABCDE);

        // R9: start pulse mid-conversion must be ignored
        @(posedge clk); #2;
        start = 1'b1; lin_addr = 24'd5000; page_sel = 1'b0; pow2_mode = 1'b0;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (5) @(posedge clk);
        #2 start = 1'b1; lin_addr = 24'h123456; pow2_mode = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        lat = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            lat++;
            if (done) break;
        end
        check("R9 timing", lat, 19);
        check("R9 result", dev_addr, ref_conv(5000, 0));
        repeat (30) @(negedge clk);
        check("R9 no extra run", busy, 0);
        check("R8 held", dev_addr, ref_conv(5000, 0));

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule